// File: doc/BRIEF.md
# Machine-Mode Trap Entry and Return Unit

This unit sits beside the program counter logic of a small hart that only ever runs at the machine privilege level. When the pipeline raises a trap request, the unit records why the trap happened, where it happened and a trap value. It then pushes the interrupt-enable bit onto a one-deep stack and computes the handler address from the trap-vector register. When the pipeline raises a return request, the unit pops the interrupt-enable stack and sends the pipeline back to the saved exception PC.

Every redirect leaves the unit as a one-cycle strobe with the target address next to it, one clock after the request. The cause, exception PC, trap value, trap vector and both enable bits are visible on ports. Write ports for the trap vector, the exception PC and the enable bits let the surrounding CSR file set up a handler. A separate load port records the address of a faulting access, which the next exception reports as its trap value.

Top module: `mtrap_unit`

## Requirements
- R1: After a synchronous active-low reset, `redirect`, `stat_ie`, `stat_pie`, `cause_reg`, `epc_reg`, `tval_reg` and `tvec_reg` are all zero.
- R2: On trap entry, `epc_reg` takes `trap_pc` unchanged. `cause_reg` takes `trap_irq` in bit XLEN-1 and `trap_code` in the low CODE_W bits, with zeros between. `stat_pie` takes the previous `stat_ie`, and `stat_ie` is cleared.
- R3: For an exception, or for any trap while trap-vector bit 0 is 0, the target is the stored trap vector with bits 1:0 cleared.
- R4: For an interrupt while trap-vector bit 0 is 1, the target is the stored trap vector with bits 1:0 cleared, plus 4 times `trap_code`.
- R5: For an exception with code 2 (illegal instruction), `tval_reg` is all of `trap_insn` when `trap_insn[1:0]` is 2'b11. Otherwise it is `trap_insn[15:0]` zero-extended. For an interrupt, `tval_reg` is zero.
- R6: For an exception with any code other than 2, `tval_reg` is the recorded fault address, which `flt_load` sets. Trap entry clears the record to zero, so a later exception with no new load reports zero. A load in the same cycle as a trap is dropped.
- R7: On return, `redirect` carries `epc_reg` ANDed with the PC mask, `stat_ie` takes `stat_pie`, and `stat_pie` becomes 1. The PC mask clears bit 0 when COMPRESSED is 1, and bits 1:0 when it is 0.
- R8: `tvec_reg` shows the value written through `tvec_we` with bit 1 forced to zero. All other bits, bit 0 included, read back as written.
- R9: When `trap_req` and `ret_req` are high in the same cycle, only the trap takes effect. The target is the trap target and the enable stack is pushed, not popped.
- R10: Each request cycle gives `redirect` high for exactly the next cycle, with `next_pc` holding the target. With no request, `redirect` is low in the following cycle.
- R11: A write through `epc_we` stores the value unmasked, and `epc_reg` reads it back as written. A trap in the same cycle wins over the write.
- R12: `st_we` loads `stat_ie` and `stat_pie` from `st_ie` and `st_pie`. A trap or return in the same cycle wins over the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trap_req | input | 1 | Take a trap this cycle |
| trap_irq | input | 1 | Trap is an interrupt (1) or an exception (0) |
| trap_code | input | CODE_W | Cause code of the trap |
| trap_pc | input | XLEN | PC of the trapping instruction |
| trap_insn | input | XLEN | Instruction word, used for illegal-instruction traps |
| flt_load | input | 1 | Record `flt_addr` as the fault address |
| flt_addr | input | XLEN | Faulting access address |
| ret_req | input | 1 | Return from trap this cycle |
| tvec_we | input | 1 | Write the trap vector |
| tvec_wdata | input | XLEN | Trap vector write data |
| epc_we | input | 1 | Write the exception PC |
| epc_wdata | input | XLEN | Exception PC write data |
| st_we | input | 1 | Write both enable bits |
| st_ie | input | 1 | Interrupt-enable write value |
| st_pie | input | 1 | Previous-enable write value |
| redirect | output | 1 | One-cycle strobe: fetch from `next_pc` |
| next_pc | output | XLEN | Redirect target |
| stat_ie | output | 1 | Global interrupt enable |
| stat_pie | output | 1 | Interrupt enable saved at trap entry |
| cause_reg | output | XLEN | Trap cause |
| epc_reg | output | XLEN | Exception PC (raw) |
| tval_reg | output | XLEN | Trap value |
| tvec_reg | output | XLEN | Trap vector as read (bit 1 zero) |

## Verification
The bench sets trap-vector bit 0 together with an interrupt to check the vectored offset. A design that ignored the mode bit, or applied the offset to exceptions, would land on the wrong handler. It also feeds illegal-instruction words whose low bits are and are not 2'b11. A design that always recorded the full word would leave stray upper bits in the trap value, and one that always truncated would lose them.

It takes two exceptions after a single fault-address load. A design that did not clear the record would report a stale address the second time. Return targets use odd and two-aligned saved PCs, so a design with the wrong alignment mask, or one that masked on write instead of on return, gives a different `epc_reg` or `next_pc`. A same-cycle trap and return must push the enable stack, not pop it.

// File: rtl/mtrap_pkg.sv
// Package: shared constants for the machine-mode trap unit.
// Assumes: cause codes are unsigned and the illegal-instruction code is 2.
package mtrap_pkg;

    // Exception code that selects the instruction word as trap value
    localparam int unsigned CODE_ILLEGAL = 2;

    // Low two bits that mark a full-length (non-compressed) instruction
    localparam logic [1:0] FULL_LEN_MARK = 2'b11;

    // Kind of redirect produced in a cycle
    typedef enum logic [1:0] {
        RD_NONE = 2'b00,
        RD_TRAP = 2'b01,
        RD_RET  = 2'b10
    } redir_kind_e;

endpackage

// File: rtl/mtrap_target.sv
// Module: mtrap_target
// Computes the handler address from the trap vector. The base is the vector
// with bits 1:0 cleared. Interrupts in vectored mode (vector bit 0 set) add
// four bytes per cause code.
// Assumes: purely combinational; the caller registers the result.
module mtrap_target #(
    parameter int XLEN   = 32,
    parameter int CODE_W = 5
) (
    input  logic [XLEN-1:0]   tvec,
    input  logic              is_irq,
    input  logic [CODE_W-1:0] code,
    output logic [XLEN-1:0]   target
);
    localparam logic [XLEN-1:0] BASE_MASK = ~(XLEN'(3));

    logic [XLEN-1:0] base;
    logic [XLEN-1:0] offset;

    // Pick the direct base or the vectored slot
    always_comb begin
        base   = tvec & BASE_MASK;
        offset = XLEN'(code) << 2;
        if (is_irq && tvec[0]) begin
            target = base + offset;
        end else begin
            target = base;
        end
    end
endmodule

// File: rtl/mtrap_tval.sv
// Module: mtrap_tval
// Chooses the trap value. Interrupts give zero. Illegal-instruction
// exceptions give the instruction word, cut to 16 bits when it is a
// compressed encoding. All other exceptions give the recorded fault address.
// Assumes: purely combinational; the fault record is held by the caller.
module mtrap_tval #(
    parameter int XLEN   = 32,
    parameter int CODE_W = 5
) (
    input  logic              is_irq,
    input  logic [CODE_W-1:0] code,
    input  logic [XLEN-1:0]   insn,
    input  logic [XLEN-1:0]   fault_rec,
    output logic [XLEN-1:0]   tval
);
    import mtrap_pkg::*;

    localparam int HALF_W = 16;

    // Select the trap value source by trap kind
    always_comb begin
        if (is_irq) begin
            tval = '0;
        end else if (code == CODE_W'(CODE_ILLEGAL)) begin
            if (insn[1:0] == FULL_LEN_MARK) begin
                tval = insn;
            end else begin
                tval = {{(XLEN-HALF_W){1'b0}}, insn[HALF_W-1:0]};
            end
        end else begin
            tval = fault_rec;
        end
    end
endmodule

// File: rtl/mtrap_status.sv
// Module: mtrap_status
// Holds the interrupt enable and its one-deep save slot. Trap entry pushes;
// return pops and sets the save slot to 1; a plain write loads both bits.
// Assumes: trap and return are already made mutually exclusive upstream.
module mtrap_status (
    input  logic clk,
    input  logic rst_n,
    input  logic do_trap,
    input  logic do_ret,
    input  logic wr_en,
    input  logic wr_ie,
    input  logic wr_pie,
    output logic ie,
    output logic pie
);
    logic ie_q;
    logic pie_q;

    // Update the enable stack; trap and return win over a write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q  <= 1'b0;
            pie_q <= 1'b0;
        end else if (do_trap) begin
            pie_q <= ie_q;
            ie_q  <= 1'b0;
        end else if (do_ret) begin
            ie_q  <= pie_q;
            pie_q <= 1'b1;
        end else if (wr_en) begin
            ie_q  <= wr_ie;
            pie_q <= wr_pie;
        end
    end

    assign ie  = ie_q;
    assign pie = pie_q;

    // R2
    trap_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_trap |=> (!ie_q && (pie_q == $past(ie_q))));

    // R7
    ret_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_ret && !do_trap) |=> (pie_q && (ie_q == $past(pie_q))));

    // R12
    stat_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !do_trap && !do_ret) |=> ((ie_q == $past(wr_ie)) && (pie_q == $past(wr_pie))));
endmodule

// File: rtl/mtrap_unit.sv
// Module: mtrap_unit (top)
// Trap entry and return for a hart that runs only at machine level. It
// captures cause, exception PC and trap value, keeps the trap vector and the
// fault-address record, and issues a registered one-cycle redirect.
// Assumes: at most one request per cycle is intended; if trap and return
// arrive together the trap wins.
module mtrap_unit #(
    parameter int XLEN       = 32,
    parameter int CODE_W     = 5,
    parameter int COMPRESSED = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_req,
    input  logic              trap_irq,
    input  logic [CODE_W-1:0] trap_code,
    input  logic [XLEN-1:0]   trap_pc,
    input  logic [XLEN-1:0]   trap_insn,
    input  logic              flt_load,
    input  logic [XLEN-1:0]   flt_addr,
    input  logic              ret_req,
    input  logic              tvec_we,
    input  logic [XLEN-1:0]   tvec_wdata,
    input  logic              epc_we,
    input  logic [XLEN-1:0]   epc_wdata,
    input  logic              st_we,
    input  logic              st_ie,
    input  logic              st_pie,
    output logic              redirect,
    output logic [XLEN-1:0]   next_pc,
    output logic              stat_ie,
    output logic              stat_pie,
    output logic [XLEN-1:0]   cause_reg,
    output logic [XLEN-1:0]   epc_reg,
    output logic [XLEN-1:0]   tval_reg,
    output logic [XLEN-1:0]   tvec_reg
);
    import mtrap_pkg::*;

    logic [XLEN-1:0] pc_mask;
    logic [XLEN-1:0] tvec_q;
    logic [XLEN-1:0] epc_q;
    logic [XLEN-1:0] cause_q;
    logic [XLEN-1:0] tval_q;
    logic [XLEN-1:0] fault_q;
    logic [XLEN-1:0] next_pc_q;
    logic            redirect_q;

    logic [XLEN-1:0] trap_target;
    logic [XLEN-1:0] trap_tval;
    logic [XLEN-1:0] cause_new;
    redir_kind_e     kind;

    // Alignment mask for return targets, chosen by compressed support
    generate
        if (COMPRESSED != 0) begin : g_mask_c
            assign pc_mask = {{(XLEN-1){1'b1}}, 1'b0};
        end else begin : g_mask_w
            assign pc_mask = {{(XLEN-2){1'b1}}, 2'b00};
        end
    endgenerate

    // Resolve which request is taken: trap has priority
    always_comb begin
        if (trap_req)      kind = RD_TRAP;
        else if (ret_req)  kind = RD_RET;
        else               kind = RD_NONE;
    end

    // Assemble the cause word: interrupt flag on top, code at the bottom
    always_comb begin
        cause_new               = '0;
        cause_new[CODE_W-1:0]   = trap_code;
        cause_new[XLEN-1]       = trap_irq;
    end

    mtrap_target #(.XLEN(XLEN), .CODE_W(CODE_W)) u_target (
        .tvec   (tvec_q),
        .is_irq (trap_irq),
        .code   (trap_code),
        .target (trap_target)
    );

    mtrap_tval #(.XLEN(XLEN), .CODE_W(CODE_W)) u_tval (
        .is_irq    (trap_irq),
        .code      (trap_code),
        .insn      (trap_insn),
        .fault_rec (fault_q),
        .tval      (trap_tval)
    );

    mtrap_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .do_trap (kind == RD_TRAP),
        .do_ret  (kind == RD_RET),
        .wr_en   (st_we),
        .wr_ie   (st_ie),
        .wr_pie  (st_pie),
        .ie      (stat_ie),
        .pie     (stat_pie)
    );

    // Register the redirect strobe and its target
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_q <= 1'b0;
            next_pc_q  <= '0;
        end else begin
            redirect_q <= (kind != RD_NONE);
            if (kind == RD_TRAP) begin
                next_pc_q <= trap_target;
            end else if (kind == RD_RET) begin
                next_pc_q <= epc_q & pc_mask;
            end
        end
    end

    // Capture cause, trap value and exception PC; trap wins over a write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
            tval_q  <= '0;
            epc_q   <= '0;
        end else if (kind == RD_TRAP) begin
            cause_q <= cause_new;
            tval_q  <= trap_tval;
            epc_q   <= trap_pc;
        end else if (epc_we) begin
            epc_q   <= epc_wdata;
        end
    end

    // Keep the fault-address record; taking a trap clears it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= '0;
        end else if (kind == RD_TRAP) begin
            fault_q <= '0;
        end else if (flt_load) begin
            fault_q <= flt_addr;
        end
    end

    // Hold the trap vector as written
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tvec_q <= '0;
        end else if (tvec_we) begin
            tvec_q <= tvec_wdata;
        end
    end

    assign redirect  = redirect_q;
    assign next_pc   = next_pc_q;
    assign cause_reg = cause_q;
    assign epc_reg   = epc_q;
    assign tval_reg  = tval_q;
    assign tvec_reg  = {tvec_q[XLEN-1:2], 1'b0, tvec_q[0]};

    // R2
    trap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> ((epc_q == $past(trap_pc)) && (cause_q[XLEN-1] == $past(trap_irq))
                      && (cause_q[CODE_W-1:0] == $past(trap_code))));

    // R3
    exc_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_req && !trap_irq) |=> (redirect_q && (next_pc_q[1:0] == 2'b00)
                                     && (next_pc_q[XLEN-1:2] == $past(tvec_q[XLEN-1:2]))));

    // R7
    ret_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && !trap_req) |=> (redirect_q && (next_pc_q[0] == 1'b0)
                                    && ((next_pc_q | ~pc_mask) == ($past(epc_q) | ~pc_mask))));

    // R6
    fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> (fault_q == '0));

    // R10
    redirect_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!trap_req && !ret_req) |=> !redirect_q);
endmodule

// File: tb/mtrap_unit_bench.sv
// Bench for mtrap_unit: a driver pushes expected redirect results into a
// queue, a monitor pops and compares them whenever a redirect appears.
module mtrap_unit_bench;
    localparam int XLEN     = 32;
    localparam int CODE_W   = 5;
    localparam int CLK_HALF = 5;
    localparam logic [XLEN-1:0] RET_MASK = 32'hFFFF_FFFE;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              trap_req = 1'b0, trap_irq = 1'b0;
    logic [CODE_W-1:0] trap_code = '0;
    logic [XLEN-1:0]   trap_pc = '0, trap_insn = '0;
    logic              flt_load = 1'b0;
    logic [XLEN-1:0]   flt_addr = '0;
    logic              ret_req = 1'b0;
    logic              tvec_we = 1'b0, epc_we = 1'b0, st_we = 1'b0;
    logic [XLEN-1:0]   tvec_wdata = '0, epc_wdata = '0;
    logic              st_ie = 1'b0, st_pie = 1'b0;
    logic              redirect, stat_ie, stat_pie;
    logic [XLEN-1:0]   next_pc, cause_reg, epc_reg, tval_reg, tvec_reg;

    always #CLK_HALF clk = ~clk;

    mtrap_unit #(.XLEN(XLEN), .CODE_W(CODE_W), .COMPRESSED(1)) u_mtrap_unit (
        .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_irq(trap_irq),
        .trap_code(trap_code), .trap_pc(trap_pc), .trap_insn(trap_insn),
        .flt_load(flt_load), .flt_addr(flt_addr), .ret_req(ret_req),
        .tvec_we(tvec_we), .tvec_wdata(tvec_wdata), .epc_we(epc_we),
        .epc_wdata(epc_wdata), .st_we(st_we), .st_ie(st_ie), .st_pie(st_pie),
        .redirect(redirect), .next_pc(next_pc), .stat_ie(stat_ie),
        .stat_pie(stat_pie), .cause_reg(cause_reg), .epc_reg(epc_reg),
        .tval_reg(tval_reg), .tvec_reg(tvec_reg)
    );

    typedef struct {
        logic [XLEN-1:0] npc;
        logic [XLEN-1:0] cause;
        logic [XLEN-1:0] epc;
        logic [XLEN-1:0] tval;
        logic            ie;
        logic            pie;
        string           tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fails  = 0;
    bit   finished = 1'b0;

    // Reference state kept from the requirements
    logic [XLEN-1:0] m_tvec = '0, m_epc = '0, m_fault = '0, m_cause = '0, m_tval = '0;
    logic            m_ie = 1'b0, m_pie = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Monitor: compare every redirect with the oldest expected item
    always @(negedge clk) begin
        if (rst_n && redirect) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10", "unexpected redirect", next_pc, '0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(next_pc == e.npc,     e.tag, "next_pc",   next_pc,   e.npc);
                chk(cause_reg == e.cause, e.tag, "cause_reg", cause_reg, e.cause);
                chk(epc_reg == e.epc,     e.tag, "epc_reg",   epc_reg,   e.epc);
                chk(tval_reg == e.tval,   e.tag, "tval_reg",  tval_reg,  e.tval);
                chk(stat_ie == e.ie,      e.tag, "stat_ie",   XLEN'(stat_ie),  XLEN'(e.ie));
                chk(stat_pie == e.pie,    e.tag, "stat_pie",  XLEN'(stat_pie), XLEN'(e.pie));
            end
        end
    end

    // Check that the strobe has dropped one cycle after a request (R10)
    task automatic idle_check();
        @(negedge clk);
        chk(redirect == 1'b0, "R10", "redirect after pulse", XLEN'(redirect), '0);
    endtask

    // Drive a trap (optionally with a same-cycle return) and predict it
    task automatic do_trap(input logic irq, input logic [CODE_W-1:0] code,
                           input logic [XLEN-1:0] pc, input logic [XLEN-1:0] insn,
                           input logic with_ret, input string tag);
        exp_t e;
        logic [XLEN-1:0] base;
        base = m_tvec & ~32'h3;
        e.npc = (irq && m_tvec[0]) ? base + (XLEN'(code) * 4) : base;
        e.cause = {irq, {(XLEN-1-CODE_W){1'b0}}, code};
        if (irq)                          e.tval = '0;
        else if (code == 2)               e.tval = (insn[1:0] == 2'b11) ? insn : {16'h0, insn[15:0]};
        else                              e.tval = m_fault;
        e.epc = pc;
        e.pie = m_ie;
        e.ie  = 1'b0;
        e.tag = tag;
        exp_q.push_back(e);
        m_epc = pc; m_pie = m_ie; m_ie = 1'b0; m_fault = '0;
        m_cause = e.cause; m_tval = e.tval;
        @(negedge clk);
        trap_req = 1'b1; trap_irq = irq; trap_code = code; trap_pc = pc;
        trap_insn = insn; ret_req = with_ret;
        @(negedge clk);
        trap_req = 1'b0; ret_req = 1'b0;
        idle_check();
    endtask

    // Drive a return and predict it
    task automatic do_ret(input string tag);
        exp_t e;
        e.npc = m_epc & RET_MASK;
        e.cause = m_cause; e.tval = m_tval; e.epc = m_epc;
        e.ie = m_pie; e.pie = 1'b1; e.tag = tag;
        exp_q.push_back(e);
        m_ie = m_pie; m_pie = 1'b1;
        @(negedge clk);
        ret_req = 1'b1;
        @(negedge clk);
        ret_req = 1'b0;
        idle_check();
    endtask

    task automatic wr_tvec(input logic [XLEN-1:0] v);
        @(negedge clk);
        tvec_we = 1'b1; tvec_wdata = v;
        @(negedge clk);
        tvec_we = 1'b0;
        m_tvec = v;
        // R8: bit 1 reads as zero, the rest as written
        chk(tvec_reg == (v & ~32'h2), "R8", "tvec_reg", tvec_reg, v & ~32'h2);
    endtask

    task automatic wr_epc(input logic [XLEN-1:0] v);
        @(negedge clk);
        epc_we = 1'b1; epc_wdata = v;
        @(negedge clk);
        epc_we = 1'b0;
        m_epc = v;
        // R11: stored unmasked
        chk(epc_reg == v, "R11", "epc_reg raw", epc_reg, v);
    endtask

    task automatic wr_stat(input logic ie, input logic pie);
        @(negedge clk);
        st_we = 1'b1; st_ie = ie; st_pie = pie;
        @(negedge clk);
        st_we = 1'b0;
        m_ie = ie; m_pie = pie;
        // R12
        chk(stat_ie == ie && stat_pie == pie, "R12", "status write",
            {30'h0, stat_pie, stat_ie}, {30'h0, pie, ie});
    endtask

    task automatic load_fault(input logic [XLEN-1:0] a);
        @(negedge clk);
        flt_load = 1'b1; flt_addr = a;
        @(negedge clk);
        flt_load = 1'b0;
        m_fault = a;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    // Stimulus
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(redirect == 1'b0 && stat_ie == 1'b0 && stat_pie == 1'b0, "R1", "flags",
            {29'h0, redirect, stat_pie, stat_ie}, '0);
        chk(cause_reg == '0 && epc_reg == '0, "R1", "cause|epc", cause_reg | epc_reg, '0);
        chk(tval_reg == '0 && tvec_reg == '0, "R1", "tval|tvec", tval_reg | tvec_reg, '0);

        wr_tvec(32'h0000_1003);
        wr_stat(1'b1, 1'b0);
        load_fault(32'hDEAD_BEE0);
        // R3 R6 R2: exception with recorded fault address, vectored bit ignored
        do_trap(1'b0, 5'd5, 32'h0000_0200, 32'h0, 1'b0, "R6");
        // R7: return restores enable
        do_ret("R7");
        // R6: record cleared, second exception reports zero
        do_trap(1'b0, 5'd7, 32'h0000_0300, 32'h0, 1'b0, "R6");
        do_ret("R7");
        // R4: vectored interrupt
        do_trap(1'b1, 5'd3, 32'h0000_0404, 32'h0, 1'b0, "R4");
        do_trap(1'b1, 5'd11, 32'h0000_0408, 32'h0, 1'b0, "R4");
        // R5: illegal instruction, full and compressed encodings
        do_trap(1'b0, 5'd2, 32'h0000_0500, 32'h1234_5673, 1'b0, "R5");
        do_trap(1'b0, 5'd2, 32'h0000_0502, 32'hABCD_1235, 1'b0, "R5");
        // R3: direct mode with an interrupt
        wr_tvec(32'h0000_2002);
        do_trap(1'b1, 5'd3, 32'h0000_0600, 32'h0, 1'b0, "R3");
        // R11 R7: raw epc write, mask applied on return
        wr_epc(32'h0000_4001);
        do_ret("R7");
        wr_epc(32'h0000_4002);
        do_ret("R7");
        // R9: trap and return together, trap wins
        wr_stat(1'b1, 1'b0);
        do_trap(1'b0, 5'd4, 32'h0000_0700, 32'h0, 1'b1, "R9");

        repeat (2) @(negedge clk);
        chk(exp_q.size() == 0, "R10", "missing redirects", XLEN'(exp_q.size()), '0);
        finish_run();
    end
endmodule